// File: doc/BRIEF.md
# Two-Way Timestamp Delay and Offset Engine

This block sits in a slave node that takes part in a two-way time transfer with a master. It sees one stream of already-decoded message events. For each event it gets a kind, a sequence number and a payload timestamp. When a sync event or a local delay-request transmit event is accepted, the block samples the node's own free-running time (seconds and nanoseconds).

The master's send time of a sync (T1) comes later, in a follow-up message. The master's receive time of the slave's delay request (T4) comes back in a response. The sync and delay-request exchanges run at their own rates. A result is formed only when the latest sync pair (T1, T2) and the latest delay pair (T3, T4) are both complete.

The block then reports the mean path delay and the clock offset in signed nanoseconds on a valid/ready result port. It holds further input messages back until that result has been taken. The message port is valid/ready as well. A message is taken on a clock edge where both `msg_valid` and `msg_ready` are high. `msg_ready` is low while a result is being formed or waits unaccepted. A result stays valid, and does not change, until `res_ready` is seen high on a clock edge.

Top module: `ptp_slave_engine`

## Requirements
- R1: After reset, `res_valid` is 0 and `msg_ready` is 1.
- R2: `msg_kind` is coded as 0 = sync received, 1 = follow-up, 2 = delay request sent, 3 = delay response. An accepted sync stores `now_sec`/`now_ns` of its accepting cycle as T2. An accepted delay request stores them as T3. Neither uses the payload fields.
- R3: A follow-up whose `msg_seq` equals that of the pending sync supplies T1 from `msg_sec`/`msg_ns` and completes the sync pair. A follow-up with any other sequence number is dropped and completes nothing.
- R4: A delay response whose `msg_seq` equals that of the pending delay request supplies T4 from its payload and completes the delay pair. A mismatching response is dropped.
- R5: Delay = floor(((T2−T1)+(T4−T3))/2), rounding toward minus infinity for odd or negative sums.
- R6: Offset = (T2−T1) − delay, signed.
- R7: The differences are taken in nanoseconds over whole timestamps (seconds × 10^9 + nanoseconds), so a seconds boundary between two timestamps gives the correct result.
- R8: Each result clears the delay pair. The sync pair is kept, so a later completed delay exchange yields a new result against the same sync pair.
- R9: A new sync cancels the previous sync pair. No result is produced until its own follow-up arrives, even if a delay pair completes meanwhile.
- R10: While `res_valid` is high and `res_ready` is low, the result and its valid stay unchanged and `msg_ready` is 0.
- R11: `res_valid` rises at the first clock edge after the edge that accepted the message completing both pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_sec | input | 48 | Local time, seconds |
| now_ns | input | 32 | Local time, nanoseconds |
| msg_valid | input | 1 | Message event present |
| msg_ready | output | 1 | Engine can take a message |
| msg_kind | input | 2 | Message kind code |
| msg_seq | input | 16 | Message sequence number |
| msg_sec | input | 48 | Payload timestamp, seconds |
| msg_ns | input | 32 | Payload timestamp, nanoseconds |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_delay | output | 64 | Mean path delay, signed ns |
| res_offset | output | 64 | Clock offset, signed ns |

## Verification
Local timestamps are taken in the message's accepting cycle. Sequence matching and pair completion also take effect at that edge, and the result registers load one edge later. The bench drives each message on a falling edge and lowers `msg_valid` on the falling edge after acceptance. It first checks that `res_valid` is still low there, then checks delay, offset and valid on the next falling edge, exactly one cycle on. Hold and stall checks are taken one further cycle later with `res_ready` low. Cases that must give no result are checked over two falling edges after the last message.

// File: rtl/ptp_eng_pkg.sv
package ptp_eng_pkg;
  typedef enum logic [1:0] {
    MSG_SYNC   = 2'd0,
    MSG_FOLLOW = 2'd1,
    MSG_DREQ   = 2'd2,
    MSG_DRESP  = 2'd3
  } msg_kind_e;
endpackage

// File: rtl/ptp_pair_tracker.sv
module ptp_pair_tracker #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 32,
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_evt,
  input  logic             close_evt,
  input  logic             clear_pair,
  input  logic [SEQ_W-1:0] seq_in,
  input  logic [SEC_W-1:0] local_sec,
  input  logic [NS_W-1:0]  local_ns,
  input  logic [SEC_W-1:0] pay_sec,
  input  logic [NS_W-1:0]  pay_ns,
  output logic             pair_valid,
  output logic [SEC_W-1:0] loc_sec,
  output logic [NS_W-1:0]  loc_ns,
  output logic [SEC_W-1:0] rem_sec,
  output logic [NS_W-1:0]  rem_ns
);
  logic             pend;
  logic [SEQ_W-1:0] pend_seq;
  logic             seq_hit;

  assign seq_hit = (seq_in == pend_seq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      pend_seq   <= '0;
      pair_valid <= 1'b0;
      loc_sec    <= '0;
      loc_ns     <= '0;
      rem_sec    <= '0;
      rem_ns     <= '0;
    end else begin
      if (clear_pair) pair_valid <= 1'b0;
      if (open_evt) begin
        // new local event starts a fresh pair (R9)
        pend       <= 1'b1;
        pend_seq   <= seq_in;
        pair_valid <= 1'b0;
        loc_sec    <= local_sec;
        loc_ns     <= local_ns;
      end else if (close_evt && pend && seq_hit) begin
        rem_sec    <= pay_sec;
        rem_ns     <= pay_ns;
        pair_valid <= 1'b1;
        pend       <= 1'b0;
      end
    end
  end

  assert_pair_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pair_valid && pend));

  assert_close_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pair_valid) |-> $past(close_evt && pend && seq_hit));
endmodule

// File: rtl/ptp_delay_calc.sv
module ptp_delay_calc #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 32,
  parameter int OUT_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  logic [SEC_W-1:0]        t1_sec,
  input  logic [NS_W-1:0]         t1_ns,
  input  logic [SEC_W-1:0]        t2_sec,
  input  logic [NS_W-1:0]         t2_ns,
  input  logic [SEC_W-1:0]        t3_sec,
  input  logic [NS_W-1:0]         t3_ns,
  input  logic [SEC_W-1:0]        t4_sec,
  input  logic [NS_W-1:0]         t4_ns,
  output logic signed [OUT_W-1:0] delay_q,
  output logic signed [OUT_W-1:0] offset_q
);
  localparam int DIFF_W = SEC_W + NS_W + 2;
  localparam logic signed [DIFF_W-1:0] NS_PER_SEC = DIFF_W'(1000000000);

  function automatic logic signed [DIFF_W-1:0] span(
    input logic [SEC_W-1:0] late_s, input logic [NS_W-1:0] late_n,
    input logic [SEC_W-1:0] early_s, input logic [NS_W-1:0] early_n);
    logic signed [DIFF_W-1:0] ds, dn;
    ds = $signed({{(DIFF_W-SEC_W){1'b0}}, late_s}) - $signed({{(DIFF_W-SEC_W){1'b0}}, early_s});
    dn = $signed({{(DIFF_W-NS_W){1'b0}}, late_n}) - $signed({{(DIFF_W-NS_W){1'b0}}, early_n});
    return ds * NS_PER_SEC + dn;
  endfunction

  logic signed [DIFF_W-1:0] d_ms, d_sm, sum, dly, off;

  always_comb begin
    d_ms = span(t2_sec, t2_ns, t1_sec, t1_ns);
    d_sm = span(t4_sec, t4_ns, t3_sec, t3_ns);
    sum  = d_ms + d_sm;
    dly  = sum >>> 1;
    off  = d_ms - dly;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delay_q  <= '0;
      offset_q <= '0;
    end else if (go) begin
      delay_q  <= dly[OUT_W-1:0];
      offset_q <= off[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/ptp_slave_engine.sv
module ptp_slave_engine #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 32,
  parameter int SEQ_W = 16,
  parameter int OUT_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SEC_W-1:0]        now_sec,
  input  logic [NS_W-1:0]         now_ns,
  input  logic                    msg_valid,
  output logic                    msg_ready,
  input  logic [1:0]              msg_kind,
  input  logic [SEQ_W-1:0]        msg_seq,
  input  logic [SEC_W-1:0]        msg_sec,
  input  logic [NS_W-1:0]         msg_ns,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic signed [OUT_W-1:0] res_delay,
  output logic signed [OUT_W-1:0] res_offset
);
  import ptp_eng_pkg::*;

  msg_kind_e        kind;
  logic             acc, fire;
  logic             sync_ok, dly_ok;
  logic [SEC_W-1:0] t1_sec, t2_sec, t3_sec, t4_sec;
  logic [NS_W-1:0]  t1_ns, t2_ns, t3_ns, t4_ns;

  assign kind      = msg_kind_e'(msg_kind);
  assign fire      = sync_ok && dly_ok && !res_valid;
  assign msg_ready = !res_valid && !fire;
  assign acc       = msg_valid && msg_ready;

  ptp_pair_tracker #(.SEC_W(SEC_W), .NS_W(NS_W), .SEQ_W(SEQ_W)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .open_evt(acc && kind == MSG_SYNC),
    .close_evt(acc && kind == MSG_FOLLOW),
    .clear_pair(1'b0),
    .seq_in(msg_seq), .local_sec(now_sec), .local_ns(now_ns),
    .pay_sec(msg_sec), .pay_ns(msg_ns),
    .pair_valid(sync_ok),
    .loc_sec(t2_sec), .loc_ns(t2_ns), .rem_sec(t1_sec), .rem_ns(t1_ns));

  ptp_pair_tracker #(.SEC_W(SEC_W), .NS_W(NS_W), .SEQ_W(SEQ_W)) u_dly (
    .clk(clk), .rst_n(rst_n),
    .open_evt(acc && kind == MSG_DREQ),
    .close_evt(acc && kind == MSG_DRESP),
    .clear_pair(fire),
    .seq_in(msg_seq), .local_sec(now_sec), .local_ns(now_ns),
    .pay_sec(msg_sec), .pay_ns(msg_ns),
    .pair_valid(dly_ok),
    .loc_sec(t3_sec), .loc_ns(t3_ns), .rem_sec(t4_sec), .rem_ns(t4_ns));

  ptp_delay_calc #(.SEC_W(SEC_W), .NS_W(NS_W), .OUT_W(OUT_W)) u_calc (
    .clk(clk), .rst_n(rst_n), .go(fire),
    .t1_sec(t1_sec), .t1_ns(t1_ns), .t2_sec(t2_sec), .t2_ns(t2_ns),
    .t3_sec(t3_sec), .t3_ns(t3_ns), .t4_sec(t4_sec), .t4_ns(t4_ns),
    .delay_q(res_delay), .offset_q(res_offset));

  always_ff @(posedge clk) begin
    if (!rst_n)         res_valid <= 1'b0;
    else if (fire)      res_valid <= 1'b1;
    else if (res_ready) res_valid <= 1'b0;
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_delay) && $stable(res_offset));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !msg_ready);

  assert_fire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(sync_ok && dly_ok));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> !dly_ok);
endmodule

// File: tb/sim_ptp_slave_engine.sv
`timescale 1ns/1ps
module sim_ptp_slave_engine;
  import ptp_eng_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst_n;
  logic [47:0]        now_sec, msg_sec;
  logic [31:0]        now_ns, msg_ns;
  logic               msg_valid, msg_ready, res_valid, res_ready;
  logic [1:0]         msg_kind;
  logic [15:0]        msg_seq;
  logic signed [63:0] res_delay, res_offset;

  int total = 0;
  int bad = 0;

  ptp_slave_engine u0 (
    .clk(clk), .rst_n(rst_n), .now_sec(now_sec), .now_ns(now_ns),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_seq(msg_seq), .msg_sec(msg_sec), .msg_ns(msg_ns),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_delay(res_delay), .res_offset(res_offset));

  // t1s,t1n,t2s,t2n,t3s,t3n,t4s,t4n,delay,offset
  localparam longint VEC [6][10] = '{
    '{10, 1000, 10, 1600, 10, 5000, 10, 5400, 500, 100},
    '{5, 999999900, 6, 100, 6, 500, 6, 700, 200, 0},
    '{100, 0, 100, 50, 100, 1000, 100, 1350, 200, -150},
    '{7, 0, 7, 301, 7, 10, 7, 10, 150, 151},
    '{1, 10, 1, 7, 1, 0, 1, 0, -2, -1},
    '{1000, 0, 1001, 0, 1001, 0, 1001, 0, 500000000, 500000000}
  };

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] k, int seq, longint s, longint n);
    @(negedge clk);
    while (!msg_ready) @(negedge clk);
    msg_kind = k;
    msg_seq  = 16'(seq);
    if (k == MSG_SYNC || k == MSG_DREQ) begin
      now_sec = 48'(s); now_ns = 32'(n);
      msg_sec = 48'h5A5A; msg_ns = 32'd13;
    end else begin
      msg_sec = 48'(s); msg_ns = 32'(n);
      now_sec = 48'h777; now_ns = 32'd999;
    end
    msg_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic expect_result(string tag, longint d, longint o);
    chk({tag, " R11 not early"}, longint'(res_valid), 0);
    @(negedge clk);
    chk({tag, " R11 valid"}, longint'(res_valid), 1);
    chk({tag, " R5 delay"}, res_delay, d);
    chk({tag, " R6 offset"}, res_offset, o);
  endtask

  task automatic expect_none(string tag);
    @(negedge clk);
    chk(tag, longint'(res_valid), 0);
    @(negedge clk);
    chk(tag, longint'(res_valid), 0);
  endtask

  task automatic take();
    @(negedge clk); res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk); res_ready = 1'b0;
    chk("R10 released", longint'(res_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R11 watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; msg_valid = 1'b0; res_ready = 1'b0;
    msg_kind = '0; msg_seq = '0; msg_sec = '0; msg_ns = '0;
    now_sec = '0; now_ns = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 res_valid", longint'(res_valid), 0);
    chk("R1 msg_ready", longint'(msg_ready), 1);
    rst_n = 1'b1;

    // vector table: R2 R5 R6 R7 R10 R11
    for (int i = 0; i < 6; i++) begin
      send(MSG_SYNC,   10 + i, VEC[i][2], VEC[i][3]);
      send(MSG_FOLLOW, 10 + i, VEC[i][0], VEC[i][1]);
      send(MSG_DREQ,   20 + i, VEC[i][4], VEC[i][5]);
      send(MSG_DRESP,  20 + i, VEC[i][6], VEC[i][7]);
      expect_result("R2 R7 vec", VEC[i][8], VEC[i][9]);
      @(negedge clk);
      chk("R10 held", longint'(res_valid), 1);
      chk("R10 stable", res_offset, VEC[i][9]);
      chk("R10 stall", longint'(msg_ready), 0);
      take();
    end

    // R3: mismatched follow-up is dropped
    send(MSG_SYNC,   100, 50, 1000);
    send(MSG_FOLLOW, 101, 50, 0);
    send(MSG_DREQ,   200, 50, 2000);
    send(MSG_DRESP,  200, 50, 2200);
    expect_none("R3 no result on bad follow-up");
    send(MSG_FOLLOW, 100, 50, 800);
    expect_result("R3 matched", 200, 0);
    take();

    // R8: new delay round reuses kept sync pair
    send(MSG_DREQ,  201, 50, 3000);
    send(MSG_DRESP, 201, 50, 3600);
    expect_result("R8 reuse", 400, -200);
    take();

    // R4: mismatched delay response is dropped
    send(MSG_DREQ,  202, 50, 4000);
    send(MSG_DRESP, 203, 50, 4100);
    expect_none("R4 no result on bad response");
    send(MSG_DRESP, 202, 50, 4000);
    expect_result("R4 matched", 100, 100);
    take();

    // R9: new sync cancels the old sync pair
    send(MSG_SYNC,  300, 60, 500);
    send(MSG_DREQ,  301, 60, 600);
    send(MSG_DRESP, 301, 60, 700);
    expect_none("R9 no result before follow-up");
    send(MSG_FOLLOW, 300, 60, 300);
    expect_result("R9 after follow-up", 150, 50);

    // R1: reset in the middle of a pending result
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 reset res_valid", longint'(res_valid), 0);
    chk("R1 reset msg_ready", longint'(msg_ready), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule